// File: doc/BRIEF.md
# JTAG-to-SWD Mode Switch Sequencer

A dual-mode debug port comes out of reset speaking JTAG. Before the first serial-wire transfer, a host must put a fixed line pattern on the shared clock and data pins to move the port into the two-wire mode. This block generates that pattern: a long run of ones, a 16-bit select code, a second long run of ones, and a short run of zeros. It uses the same pattern as a line reset when the link has lost framing.

Between sequences the block passes the transfer engine's clock, data and output enable to the pins. A start pulse takes the pins over. The sequencer then drives them with the same half-period divider and the same setup spacing as the engine. When it finishes, it pulses done and gives the pins back to the engine. Reading the identification register afterwards is the engine's job.

Top module: `swd_switch_seq`

## Requirements
- R1: While reset is held and right after it, busy_o and done_o are 0 and the pins follow the engine inputs.
- R2: While idle, swclk_o, swdio_o and swdio_oe_o equal eng_swclk_i, eng_swdio_i and eng_swdio_oe_i in the same cycle.
- R3: The first phase drives swdio_o to 1 for HIGH1_BITS clock rising edges. The default is 56. An elaboration check rejects any value of 50 or less.
- R4: The second phase sends 16'h79E7 (binary 0111100111100111), bit 15 first, one bit per rising edge.
- R5: The third phase drives swdio_o to 1 for HIGH3_BITS rising edges. The default is 56, and values of 50 or less are rejected.
- R6: The last phase drives swdio_o to 0 for LOW_BITS rising edges. The default is 4, and values of 2 or less are rejected. The line is 0 in the final cycle before release.
- R7: swdio_o changes only at the start of a bit, with swclk_o low. It is stable for HALF_CYC cycles before each rising edge.
- R8: Each bit lasts 2*HALF_CYC cycles, with the clock low for the first half and high for the second. The clock is high in the last busy cycle.
- R9: done_o is a one-cycle pulse in the first cycle after busy_o falls.
- R10: A start_i pulse while busy_o is 1 has no effect. The sequence still has exactly HIGH1_BITS+16+HIGH3_BITS+LOW_BITS rising edges.
- R11: swdio_oe_o is 1 in every busy cycle.
- R12: A start after done replays the whole sequence identically.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin the switch sequence (ignored while busy) |
| busy_o | output | 1 | Sequencer owns the pins |
| done_o | output | 1 | One-cycle pulse at the end of the sequence |
| eng_swclk_i | input | 1 | Clock from the transfer engine |
| eng_swdio_i | input | 1 | Data from the transfer engine |
| eng_swdio_oe_i | input | 1 | Output enable from the transfer engine |
| swclk_o | output | 1 | Clock pin |
| swdio_o | output | 1 | Data pin output value |
| swdio_oe_o | output | 1 | Data pin output enable |

## Verification
The bench builds the block with HIGH1_BITS and HIGH3_BITS at 51, LOW_BITS at 3 and HALF_CYC at 2. These are the smallest values the elaboration check accepts. A 121-bit sequence at four cycles per bit lets every run be compared bit by bit against a table. It also puts the boundary run lengths, the adjacent one-runs where the code's tail meets the third phase, and the setup spacing of two cycles before each rising edge within direct observation.

// File: rtl/swd_seq_pkg.sv
package swd_seq_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_HIGH1,
    PH_CODE,
    PH_HIGH3,
    PH_LOW
  } phase_e;

  localparam logic [15:0] SWITCH_CODE = 16'h79E7;
  localparam int CODE_BITS = 16;
endpackage

// File: rtl/swd_bit_timer.sv
module swd_bit_timer #(
  parameter int HALF_CYC = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic sclk_o,
  output logic bit_end_o
);
  localparam int PERIOD = 2 * HALF_CYC;
  localparam int CW = $clog2(PERIOD);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= '0;
    else if (!run_i)                  cnt_q <= '0;
    else if (cnt_q == CW'(PERIOD-1))  cnt_q <= '0;
    else                              cnt_q <= cnt_q + 1'b1;
  end

  // low half first gives the data its setup time
  assign sclk_o    = run_i && (cnt_q >= CW'(HALF_CYC));
  assign bit_end_o = run_i && (cnt_q == CW'(PERIOD-1));
endmodule

// File: rtl/swd_seq_ctrl.sv
module swd_seq_ctrl
  import swd_seq_pkg::*;
#(
  parameter int HIGH1_BITS = 56,
  parameter int HIGH3_BITS = 56,
  parameter int LOW_BITS   = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic bit_end_i,
  output logic busy_o,
  output logic done_o,
  output logic data_o
);
  localparam int MAX_A = (HIGH1_BITS > HIGH3_BITS) ? HIGH1_BITS : HIGH3_BITS;
  localparam int MAX_B = (LOW_BITS > CODE_BITS) ? LOW_BITS : CODE_BITS;
  localparam int MAXN  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int IW    = $clog2(MAXN + 1);

  phase_e        phase_q;
  logic [IW-1:0] idx_q;
  logic [IW-1:0] last_idx;
  logic [3:0]    code_sel;
  logic          done_q;

  always_comb begin
    unique case (phase_q)
      PH_HIGH1: last_idx = IW'(HIGH1_BITS - 1);
      PH_CODE:  last_idx = IW'(CODE_BITS - 1);
      PH_HIGH3: last_idx = IW'(HIGH3_BITS - 1);
      PH_LOW:   last_idx = IW'(LOW_BITS - 1);
      default:  last_idx = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      idx_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (phase_q == PH_IDLE) begin
        if (start_i) begin
          phase_q <= PH_HIGH1;
          idx_q   <= '0;
        end
      end else if (bit_end_i) begin
        if (idx_q == last_idx) begin
          idx_q <= '0;
          unique case (phase_q)
            PH_HIGH1: phase_q <= PH_CODE;
            PH_CODE:  phase_q <= PH_HIGH3;
            PH_HIGH3: phase_q <= PH_LOW;
            default: begin
              phase_q <= PH_IDLE;
              done_q  <= 1'b1;
            end
          endcase
        end else begin
          idx_q <= idx_q + 1'b1;
        end
      end
    end
  end

  assign code_sel = 4'd15 - idx_q[3:0];

  always_comb begin
    unique case (phase_q)
      PH_CODE: data_o = SWITCH_CODE[code_sel];
      PH_LOW:  data_o = 1'b0;
      default: data_o = 1'b1;
    endcase
  end

  assign busy_o = (phase_q != PH_IDLE);
  assign done_o = done_q;
endmodule

// File: rtl/swd_line_mux.sv
module swd_line_mux (
  input  logic sel_seq_i,
  input  logic seq_clk_i,
  input  logic seq_dio_i,
  input  logic eng_clk_i,
  input  logic eng_dio_i,
  input  logic eng_oe_i,
  output logic clk_o,
  output logic dio_o,
  output logic oe_o
);
  assign clk_o = sel_seq_i ? seq_clk_i : eng_clk_i;
  assign dio_o = sel_seq_i ? seq_dio_i : eng_dio_i;
  assign oe_o  = sel_seq_i ? 1'b1      : eng_oe_i;
endmodule

// File: rtl/swd_switch_seq.sv
module swd_switch_seq #(
  parameter int HIGH1_BITS = 56,
  parameter int HIGH3_BITS = 56,
  parameter int LOW_BITS   = 4,
  parameter int HALF_CYC   = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o,
  output logic done_o,
  input  logic eng_swclk_i,
  input  logic eng_swdio_i,
  input  logic eng_swdio_oe_i,
  output logic swclk_o,
  output logic swdio_o,
  output logic swdio_oe_o
);
  if (HIGH1_BITS <= 50) begin : g_bad_h1
    $error("HIGH1_BITS must exceed 50");
  end
  if (HIGH3_BITS <= 50) begin : g_bad_h3
    $error("HIGH3_BITS must exceed 50");
  end
  if (LOW_BITS <= 2) begin : g_bad_lo
    $error("LOW_BITS must exceed 2");
  end
  if (HALF_CYC < 1) begin : g_bad_half
    $error("HALF_CYC must be at least 1");
  end

  logic busy, bit_end, seq_clk, seq_dio;

  swd_seq_ctrl #(
    .HIGH1_BITS(HIGH1_BITS),
    .HIGH3_BITS(HIGH3_BITS),
    .LOW_BITS  (LOW_BITS)
  ) u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .bit_end_i(bit_end),
    .busy_o   (busy),
    .done_o   (done_o),
    .data_o   (seq_dio)
  );

  swd_bit_timer #(.HALF_CYC(HALF_CYC)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (busy),
    .sclk_o   (seq_clk),
    .bit_end_o(bit_end)
  );

  swd_line_mux u_mux (
    .sel_seq_i(busy),
    .seq_clk_i(seq_clk),
    .seq_dio_i(seq_dio),
    .eng_clk_i(eng_swclk_i),
    .eng_dio_i(eng_swdio_i),
    .eng_oe_i (eng_swdio_oe_i),
    .clk_o    (swclk_o),
    .dio_o    (swdio_o),
    .oe_o     (swdio_oe_o)
  );

  assign busy_o = busy;
endmodule

// File: rtl/swd_switch_seq_chk.sv
module swd_switch_seq_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic busy_o,
  input logic done_o,
  input logic swclk_o,
  input logic swdio_o,
  input logic swdio_oe_o
);
  p_done_single_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_done_after_busy_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && $past(busy_o)));

  p_oe_held_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> swdio_oe_o);

  p_setup_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(swclk_o) && busy_o && $past(busy_o)) |-> $stable(swdio_o));

  p_end_clk_high_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> $past(swclk_o));

  p_end_low_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> !$past(swdio_o));
endmodule

bind swd_switch_seq swd_switch_seq_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .swclk_o   (swclk_o),
  .swdio_o   (swdio_o),
  .swdio_oe_o(swdio_oe_o)
);

// File: tb/tb_swd_switch_seq.sv
`timescale 1ns/1ps
module tb_swd_switch_seq;
  localparam int H1 = 51;
  localparam int H3 = 51;
  localparam int LO = 3;
  localparam int HALF = 2;
  localparam int NBITS = H1 + 16 + H3 + LO;
  localparam int NRUN = 9;
  localparam int RUN_LEN [NRUN] = '{51, 1, 4, 2, 4, 2, 3, 51, 3};
  localparam bit RUN_VAL [NRUN] = '{1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0};

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0;
  logic eng_swclk_i = 1'b0, eng_swdio_i = 1'b0, eng_swdio_oe_i = 1'b0;
  logic busy_o, done_o, swclk_o, swdio_o, swdio_oe_o;

  int n_chk = 0, n_bad = 0;
  int cyc = 0, last_rise = 0, nrise = 0;
  logic prev_clk = 1'b0, prev_dio = 1'b0;
  logic cap [NBITS];

  always #2.5 clk = ~clk;

  swd_switch_seq #(.HIGH1_BITS(H1), .HIGH3_BITS(H3), .LOW_BITS(LO), .HALF_CYC(HALF)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .busy_o(busy_o), .done_o(done_o),
    .eng_swclk_i(eng_swclk_i), .eng_swdio_i(eng_swdio_i), .eng_swdio_oe_i(eng_swdio_oe_i),
    .swclk_o(swclk_o), .swdio_o(swdio_o), .swdio_oe_o(swdio_oe_o));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  // monitor at the falling edge
  always @(negedge clk) begin
    cyc++;
    if (busy_o) begin
      check(swdio_oe_o == 1'b1, "R11 oe while busy", swdio_oe_o, 1);
      if (swclk_o && !prev_clk) begin
        check(swdio_o == prev_dio, "R7 data stable before rise", swdio_o, prev_dio);
        if (nrise > 0)
          check(cyc - last_rise == 2*HALF, "R8 bit period", cyc - last_rise, 2*HALF);
        if (nrise < NBITS) cap[nrise] = swdio_o;
        nrise++;
        last_rise = cyc;
      end
    end
    prev_clk = swclk_o;
    prev_dio = swdio_o;
  end

  always @(posedge clk) if (cyc > 20000) begin
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=<20000", cyc);
    finish_run();
  end

  task automatic pulse_start();
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
  endtask

  task automatic run_and_compare(input string tag, input bit poke);
    int guard;
    nrise = 0;
    pulse_start();
    if (poke) begin
      repeat (10) @(negedge clk);
      start_i = 1'b1;  // R10 start while busy
      @(negedge clk); start_i = 1'b0;
    end
    guard = 0;
    while (!done_o && guard < 5000) begin
      @(negedge clk); guard++;
    end
    check(done_o == 1'b1, "R9 done seen", done_o, 1);
    check(busy_o == 1'b0, "R9 busy low with done", busy_o, 0);
    check(nrise == NBITS, "R10 rise count", nrise, NBITS);
    @(negedge clk);
    check(done_o == 1'b0, "R9 done one cycle", done_o, 0);
    begin
      int b = 0;
      for (int r = 0; r < NRUN; r++) begin
        for (int k = 0; k < RUN_LEN[r]; k++) begin
          string req;
          if (b < H1) req = "R3 phase1 high";
          else if (b < H1 + 16) req = "R4 code bit";
          else if (b < H1 + 16 + H3) req = "R5 phase3 high";
          else req = "R6 phase4 low";
          check(cap[b] == RUN_VAL[r], {tag, " ", req}, cap[b], RUN_VAL[r]);
          b++;
        end
      end
    end
  endtask

  initial begin
    eng_swclk_i = 1'b1; eng_swdio_i = 1'b0; eng_swdio_oe_i = 1'b1;
    repeat (3) @(negedge clk);
    check(busy_o == 1'b0, "R1 busy in reset", busy_o, 0);
    check(done_o == 1'b0, "R1 done in reset", done_o, 0);
    check(swclk_o == 1'b1, "R1 clk follows engine", swclk_o, 1);
    rst_ni = 1'b1;
    @(negedge clk);
    check(busy_o == 1'b0 && done_o == 1'b0, "R1 after reset", busy_o, 0);

    // R2 idle pass-through
    for (int v = 0; v < 8; v++) begin
      eng_swclk_i = v[0]; eng_swdio_i = v[1]; eng_swdio_oe_i = v[2];
      @(negedge clk);
      check({swclk_o, swdio_o, swdio_oe_o} == {v[0], v[1], v[2]},
            "R2 pass-through", {swclk_o, swdio_o, swdio_oe_o}, {v[0], v[1], v[2]});
    end
    eng_swclk_i = 1'b0; eng_swdio_i = 1'b1; eng_swdio_oe_i = 1'b0;

    run_and_compare("run1", 1'b1);
    check(swdio_oe_o == 1'b0 && swdio_o == 1'b1, "R2 returned to engine",
          {swdio_o, swdio_oe_o}, 2);

    run_and_compare("R12 rerun", 1'b0);
    check(busy_o == 1'b0, "R12 idle after rerun", busy_o, 0);

    finish_run();
  end
endmodule